// File: doc/BRIEF.md
# Four-channel PWM control register front-end

This block is the register-facing side of a four-channel pulse-width modulator. A simple request port carries one read or one write per cycle. The block turns these accesses into one-cycle start and stop strobes for the channel engines. It holds each channel's mode, duty, period and update values and drives them toward the channels. It also shows the running flag each channel reports.

Each channel engine raises a one-cycle event at the end of every period. The block collects these events into a sticky status word. Reading that word returns its contents and clears them, so software can wait for the next period boundary before it reconfigures or stops a channel. The waveform generators themselves, interrupt-line generation and any bus bridging are outside the block.

Top module: `pwm_reg_frontend`

## Requirements
- R1: After reset, `rsp_rdata`, all start, stop and update strobes, every channel mode, duty, period and update value, and the sticky event status are zero.
- R2: A write to offset 0x04 raises `ch_start[n]` for exactly one cycle, in the cycle after the write, for every bit n of the write data that is 1. Zero bits raise nothing.
- R3: A write to offset 0x08 raises `ch_stop[n]` for exactly one cycle, in the cycle after the write, for every bit n of the write data that is 1. Zero bits raise nothing. Start and stop strobes are never both high for the same channel.
- R4: A read of offset 0x0C returns `ch_running` in bits 3:0 and zero above. With all four channels running it reads 0x0F.
- R5: A one-cycle pulse on `ch_period_end[n]` sets bit n of the event status at offset 0x1C. The bit stays set until that offset is read.
- R6: A read of offset 0x1C returns the event status held before the access and clears every bit it returned.
- R7: An event that arrives in the same cycle as a clearing read of offset 0x1C is not in that read's data. It stays set and appears in the next read.
- R8: The channel n window starts at 0x200 + n*0x20. Inside a window, mode is at 0x00 (11 bits wide), duty at 0x04 (16 bits), period at 0x08 (16 bits) and update at 0x10 (16 bits). Each reads back the last value written, with data bits above the register width dropped and read as zero. Each is driven on the matching flat output slice `[n*W +: W]`.
- R9: A write to a channel's update offset pulses that channel's `ch_upd_stb` bit for one cycle, in the cycle after the write. Writes to any other offset leave `ch_upd_stb` at zero.
- R10: Reads of unmapped offsets return zero, and writes to them change no register and raise no strobe. Offsets 0x04 and 0x08 also read as zero.
- R11: Read data appears on `rsp_rdata` in the cycle after the read access and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| ch_running | input | 4 | Running flag from each channel |
| ch_period_end | input | 4 | End-of-period event pulse from each channel |
| ch_start | output | 4 | One-cycle start strobe per channel |
| ch_stop | output | 4 | One-cycle stop strobe per channel |
| ch_upd_stb | output | 4 | One-cycle strobe after an update-register write |
| ch_mode | output | 44 | Mode value, 11 bits per channel |
| ch_duty | output | 64 | Duty value, 16 bits per channel |
| ch_period | output | 64 | Period value, 16 bits per channel |
| ch_update | output | 64 | Update value, 16 bits per channel |

## Verification
The hardest case to reach is a period-end event that lands in exactly the same cycle as the read that clears the event status. If the timing is wrong by one cycle, the test only checks the ordinary set and clear path. The bench first leaves one bit set. It then drives the event pulse and the status read from the same falling edge, so both are seen by one rising edge. It then checks that the first read returns only the older bit and that a second read returns the new one.

// File: rtl/pwm_regs_pkg.sv
package pwm_regs_pkg;
    // Global register offsets
    localparam logic [11:0] OFF_START  = 12'h004;
    localparam logic [11:0] OFF_STOP   = 12'h008;
    localparam logic [11:0] OFF_RUN    = 12'h00C;
    localparam logic [11:0] OFF_EVENTS = 12'h01C;

    // Channel window layout
    localparam logic [11:0] WIN_BASE   = 12'h200;
    localparam int          WIN_STRIDE = 32;

    // Offsets inside one channel window
    localparam logic [4:0]  COFF_MODE   = 5'h00;
    localparam logic [4:0]  COFF_DUTY   = 5'h04;
    localparam logic [4:0]  COFF_PERIOD = 5'h08;
    localparam logic [4:0]  COFF_UPDATE = 5'h10;
endpackage

// File: rtl/pwm_glob_regs.sv
module pwm_glob_regs #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic              wr_stop,
    input  logic              rd_events,
    input  logic [NUM_CH-1:0] wmask,
    input  logic [NUM_CH-1:0] period_end,
    output logic [NUM_CH-1:0] start_o,
    output logic [NUM_CH-1:0] stop_o,
    output logic [NUM_CH-1:0] events_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] start;
        logic [NUM_CH-1:0] stop;
        logic [NUM_CH-1:0] events;
    } glob_state_t;

    glob_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.start  = wr_start ? wmask : '0;
        st_d.stop   = wr_stop  ? wmask : '0;
        st_d.events = (rd_events ? '0 : st_q.events) | period_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_o  = st_q.start;
    assign stop_o   = st_q.stop;
    assign events_o = st_q.events;

    // R2
    start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.start != '0) |-> $past(wr_start));

    // R3
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.start & st_q.stop) == '0);

    // R6
    event_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_events && period_end == '0) |=> st_q.events == '0);

    // R7
    event_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_events |=> ((st_q.events & $past(period_end)) == $past(period_end)));
endmodule

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
    import pwm_regs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MODE_W = 11,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [4:0]        off,
    input  logic [DATA_W-1:0] wdata,
    output logic [MODE_W-1:0] mode_o,
    output logic [CNT_W-1:0]  duty_o,
    output logic [CNT_W-1:0]  period_o,
    output logic [CNT_W-1:0]  update_o,
    output logic              upd_stb_o,
    output logic              hit_o,
    output logic [DATA_W-1:0] rdata_o
);
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [CNT_W-1:0]  duty;
        logic [CNT_W-1:0]  period;
        logic [CNT_W-1:0]  update;
        logic              upd_stb;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic wr_mode, wr_duty, wr_period, wr_update;

    always_comb begin
        wr_mode   = sel && wr && off == COFF_MODE;
        wr_duty   = sel && wr && off == COFF_DUTY;
        wr_period = sel && wr && off == COFF_PERIOD;
        wr_update = sel && wr && off == COFF_UPDATE;

        st_d         = st_q;
        st_d.upd_stb = wr_update;
        if (wr_mode)   st_d.mode   = wdata[MODE_W-1:0];
        if (wr_duty)   st_d.duty   = wdata[CNT_W-1:0];
        if (wr_period) st_d.period = wdata[CNT_W-1:0];
        if (wr_update) st_d.update = wdata[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        hit_o   = 1'b1;
        rdata_o = '0;
        unique case (off)
            COFF_MODE:   rdata_o = DATA_W'(st_q.mode);
            COFF_DUTY:   rdata_o = DATA_W'(st_q.duty);
            COFF_PERIOD: rdata_o = DATA_W'(st_q.period);
            COFF_UPDATE: rdata_o = DATA_W'(st_q.update);
            default:     hit_o   = 1'b0;
        endcase
    end

    assign mode_o    = st_q.mode;
    assign duty_o    = st_q.duty;
    assign period_o  = st_q.period;
    assign update_o  = st_q.update;
    assign upd_stb_o = st_q.upd_stb;

    // R9
    upd_stb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.upd_stb |-> $past(sel && wr && off == COFF_UPDATE));

    // R8
    duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && wr) |=> $stable(st_q.duty));
endmodule

// File: rtl/pwm_reg_frontend.sv
module pwm_reg_frontend
    import pwm_regs_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int MODE_W = 11,
    parameter int CNT_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic [DATA_W-1:0]        rsp_rdata,
    input  logic [NUM_CH-1:0]        ch_running,
    input  logic [NUM_CH-1:0]        ch_period_end,
    output logic [NUM_CH-1:0]        ch_start,
    output logic [NUM_CH-1:0]        ch_stop,
    output logic [NUM_CH-1:0]        ch_upd_stb,
    output logic [NUM_CH*MODE_W-1:0] ch_mode,
    output logic [NUM_CH*CNT_W-1:0]  ch_duty,
    output logic [NUM_CH*CNT_W-1:0]  ch_period,
    output logic [NUM_CH*CNT_W-1:0]  ch_update
);
    localparam int STR_SH  = $clog2(WIN_STRIDE);
    localparam int WIN_END = int'(WIN_BASE) + NUM_CH * WIN_STRIDE;

    logic              is_rd, is_wr, in_win;
    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] win_idx;
    logic [4:0]        win_off;
    logic [NUM_CH-1:0] events;
    logic [NUM_CH-1:0] ch_sel, ch_hit;
    logic [DATA_W-1:0] ch_rdata [NUM_CH];

    always_comb begin
        is_rd   = req_valid && !req_write;
        is_wr   = req_valid && req_write;
        in_win  = int'(req_addr) >= int'(WIN_BASE) && int'(req_addr) < WIN_END;
        rel     = req_addr - ADDR_W'(WIN_BASE);
        win_idx = rel >> STR_SH;
        win_off = 5'(rel[STR_SH-1:0]);
    end

    pwm_glob_regs #(.NUM_CH(NUM_CH)) u_glob (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_start   (is_wr && req_addr == ADDR_W'(OFF_START)),
        .wr_stop    (is_wr && req_addr == ADDR_W'(OFF_STOP)),
        .rd_events  (is_rd && req_addr == ADDR_W'(OFF_EVENTS)),
        .wmask      (req_wdata[NUM_CH-1:0]),
        .period_end (ch_period_end),
        .start_o    (ch_start),
        .stop_o     (ch_stop),
        .events_o   (events)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        assign ch_sel[n] = req_valid && in_win && win_idx == ADDR_W'(n);
        pwm_chan_regs #(.DATA_W(DATA_W), .MODE_W(MODE_W), .CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (ch_sel[n]),
            .wr        (req_write),
            .off       (win_off),
            .wdata     (req_wdata),
            .mode_o    (ch_mode[n*MODE_W +: MODE_W]),
            .duty_o    (ch_duty[n*CNT_W +: CNT_W]),
            .period_o  (ch_period[n*CNT_W +: CNT_W]),
            .update_o  (ch_update[n*CNT_W +: CNT_W]),
            .upd_stb_o (ch_upd_stb[n]),
            .hit_o     (ch_hit[n]),
            .rdata_o   (ch_rdata[n])
        );
    end

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (is_rd) begin
            rd_d.rdata = '0;
            if (req_addr == ADDR_W'(OFF_RUN))
                rd_d.rdata = DATA_W'(ch_running);
            else if (req_addr == ADDR_W'(OFF_EVENTS))
                rd_d.rdata = DATA_W'(events);
            else if (in_win)
                for (int n = 0; n < NUM_CH; n++)
                    if (ch_sel[n] && ch_hit[n]) rd_d.rdata = ch_rdata[n];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rsp_rdata = rd_q.rdata;

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rd |=> $stable(rsp_rdata));

    // R8
    one_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_sel));
endmodule

// File: tb/tb_pwm_reg_frontend.sv
module tb_pwm_reg_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic [3:0]  ch_running = '0, ch_period_end = '0;
    logic [3:0]  ch_start, ch_stop, ch_upd_stb;
    logic [43:0] ch_mode;
    logic [63:0] ch_duty, ch_period, ch_update;

    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    pwm_reg_frontend dut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Access ends at the falling edge after the sampling rising edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 rdata", 64'(rsp_rdata), 0);
        chk("R1 strobes", 64'({ch_start, ch_stop, ch_upd_stb}), 0);
        chk("R1 mode", 64'(ch_mode), 0);
        chk("R1 duty", ch_duty | ch_period | ch_update, 0);
        rd(12'h01C);
        chk("R1 events", 64'(rsp_rdata), 0);
    endtask

    task automatic t_start_stop;
        wr(12'h004, 32'h0000_0005);
        chk("R2 start pulse", 64'(ch_start), 64'h5);
        chk("R3 no stop on start", 64'(ch_stop), 0);
        @(negedge clk);
        chk("R2 start one cycle", 64'(ch_start), 0);
        wr(12'h004, 32'h0);
        chk("R2 zero bits", 64'(ch_start), 0);
        wr(12'h008, 32'h0000_000A);
        chk("R3 stop pulse", 64'(ch_stop), 64'hA);
        @(negedge clk);
        chk("R3 stop one cycle", 64'(ch_stop), 0);
    endtask

    task automatic t_running;
        ch_running = 4'hF;
        rd(12'h00C);
        chk("R4 all running", 64'(rsp_rdata), 64'h0F);
        ch_running = 4'h6;
        rd(12'h00C);
        chk("R4 some running", 64'(rsp_rdata), 64'h06);
    endtask

    task automatic t_events;
        @(negedge clk); ch_period_end = 4'b0010;
        @(negedge clk); ch_period_end = 4'b1000;
        @(negedge clk); ch_period_end = 4'b0000;
        repeat (3) @(negedge clk);
        rd(12'h01C);
        chk("R5 sticky set", 64'(rsp_rdata), 64'hA);
        rd(12'h01C);
        chk("R6 cleared by read", 64'(rsp_rdata), 0);
        // R7: event coincides with the clearing read
        @(negedge clk); ch_period_end = 4'b0001;
        @(negedge clk); ch_period_end = 4'b0000;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h01C; ch_period_end = 4'b0100;
        @(negedge clk);
        req_valid = 1'b0; ch_period_end = 4'b0000;
        chk("R7 read excludes new event", 64'(rsp_rdata), 64'h1);
        rd(12'h01C);
        chk("R7 new event kept", 64'(rsp_rdata), 64'h4);
    endtask

    task automatic t_channels;
        for (int n = 0; n < 4; n++) begin
            logic [11:0] b;
            b = 12'h200 + 12'(n * 32);
            wr(b + 12'h00, 32'hFFFF_F800 | 32'(n));
            wr(b + 12'h04, 32'hABCD_0100 + 32'(n));
            wr(b + 12'h08, 32'h0000_2000 + 32'(n));
        end
        for (int n = 0; n < 4; n++) begin
            logic [11:0] b;
            b = 12'h200 + 12'(n * 32);
            rd(b + 12'h00);
            chk("R8 mode readback", 64'(rsp_rdata), 64'(n));
            rd(b + 12'h04);
            chk("R8 duty readback", 64'(rsp_rdata), 64'h0100 + 64'(n));
            rd(b + 12'h08);
            chk("R8 period readback", 64'(rsp_rdata), 64'h2000 + 64'(n));
            chk("R8 duty output", 64'(ch_duty[n*16 +: 16]), 64'h0100 + 64'(n));
            chk("R8 period output", 64'(ch_period[n*16 +: 16]), 64'h2000 + 64'(n));
        end
        wr(12'h200, 32'h0000_07FF);
        chk("R8 mode width", 64'(ch_mode[10:0]), 64'h7FF);
        chk("R9 no strobe on mode write", 64'(ch_upd_stb), 0);
        wr(12'h250, 32'h0000_1234);
        chk("R9 update strobe", 64'(ch_upd_stb), 64'h4);
        chk("R9 update value", 64'(ch_update[32 +: 16]), 64'h1234);
        @(negedge clk);
        chk("R9 strobe one cycle", 64'(ch_upd_stb), 0);
        rd(12'h250);
        chk("R8 update readback", 64'(rsp_rdata), 64'h1234);
    endtask

    task automatic t_unmapped;
        logic [63:0] duty_before;
        duty_before = ch_duty;
        wr(12'h20C, 32'hFFFF_FFFF);
        wr(12'h280, 32'hFFFF_FFFF);
        wr(12'h010, 32'hFFFF_FFFF);
        chk("R10 unmapped write no strobe", 64'({ch_start, ch_stop, ch_upd_stb}), 0);
        chk("R10 unmapped write no change", ch_duty, duty_before);
        rd(12'h20C);
        chk("R10 unmapped window read", 64'(rsp_rdata), 0);
        rd(12'h280);
        chk("R10 beyond last window", 64'(rsp_rdata), 0);
        rd(12'h004);
        chk("R10 start reads zero", 64'(rsp_rdata), 0);
        rd(12'h008);
        chk("R10 stop reads zero", 64'(rsp_rdata), 0);
    endtask

    task automatic t_hold;
        rd(12'h224);
        chk("R11 read data", 64'(rsp_rdata), 64'h0101);
        wr(12'h204, 32'h0000_5555);
        repeat (2) @(negedge clk);
        chk("R11 held until next read", 64'(rsp_rdata), 64'h0101);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start_stop();
        t_running();
        t_events();
        t_channels();
        t_unmapped();
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule